// File: doc/BRIEF.md
# Alignment-Aware Transfer Segmenter

This block sits on the master side of a serial memory link. It takes one transfer request at a time. A request carries a start address, a byte count and a direction flag. The block cuts the request into a chain of link commands. Every command address is naturally aligned to the width of that command, and the chain is as short as the alignment rules allow. Each command leaves the block as an opcode, an address and a length on a valid/ready output channel.

When the final command has been taken, the block pulses `done`. When a request breaks the alignment rules, it pulses `err` and issues nothing for that request. Shifting bits onto the wire and moving the payload bytes belong to other blocks. For that reason the block only flags the segment that carries the zero pad byte of an odd-sized write.

Top module: `xfer_segmenter`

## Requirements
- R1: A 2-byte segment (read opcode 0) is issued when the current address modulo 8 is 2 or 6, or when exactly 2 bytes remain. A 2-byte segment is never placed on an odd address.
- R2: If R1 does not apply, a 4-byte segment (read opcode 2) is issued when the address modulo 8 is 4 or when 6 or fewer bytes remain. Its address has its two low bits clear.
- R3: If neither R1 nor R2 applies, a burst (read opcode 4) is issued. Its length is the remaining count with the low three bits cleared, limited to 240. A 260-byte read at an address ending in hex 02 yields the lengths 2, 4, 240, 8, 4, 2.
- R4: A write uses the read opcode plus one, so write codes are 1, 3 and 5.
- R5: Each segment address equals the start address plus the lengths of all earlier segments, with 32-bit wraparound.
- R6: A read with an odd address or an odd length is rejected, and so is a write with an odd address. `err` is high for exactly the one cycle after acceptance, and no segment is issued.
- R7: A write with an odd length is padded by one byte. The last segment of such a write has `seg_pad` high, and no other segment does.
- R8: A zero-length request issues no segment. `done` is high for exactly the one cycle after acceptance.
- R9: `done` is high for exactly the one cycle after the final segment handshake. `req_ready` is low while segments are pending.
- R10: While `seg_valid` is high and `seg_ready` is low, the segment outputs stay unchanged.
- R11: After reset, `req_ready` is high and `seg_valid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Start byte address |
| req_len | input | 16 | Byte count |
| req_write | input | 1 | 1 = write, 0 = read |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Segment taken by the downstream block |
| seg_opcode | output | 3 | Command code |
| seg_addr | output | 32 | Segment byte address |
| seg_len | output | 8 | Segment byte count |
| seg_pad | output | 1 | Segment ends with the zero pad byte |
| done | output | 1 | Request finished |
| err | output | 1 | Request rejected |

## Verification
A request is accepted on a rising edge. Its first segment, or its `err` or `done` pulse, is visible one cycle later. `done` follows the edge that takes the final segment by one cycle. The bench drives and samples on falling edges. It compares a segment only in a cycle where it has itself raised `seg_ready`, and it expects the completion pulse on the falling edge after that handshake. It also expects the pulse to be gone on the falling edge after that. Stall patterns hold `seg_ready` low at chosen points so the bench can check that the outputs stay unchanged between those edges.

// File: rtl/xseg_pkg.sv
package xseg_pkg;

  typedef enum logic [1:0] {
    SEG_HALF,
    SEG_WORD,
    SEG_BURST
  } seg_kind_e;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } seq_state_e;

  localparam logic [2:0] OPC_RD_HALF  = 3'd0;
  localparam logic [2:0] OPC_RD_WORD  = 3'd2;
  localparam logic [2:0] OPC_RD_BURST = 3'd4;

  function automatic logic [2:0] kind_opcode(seg_kind_e kind, logic is_write);
    logic [2:0] base;
    case (kind)
      SEG_HALF: base = OPC_RD_HALF;
      SEG_WORD: base = OPC_RD_WORD;
      default:  base = OPC_RD_BURST;
    endcase
    return base | {2'b00, is_write};
  endfunction

endpackage

// File: rtl/xseg_rst_sync.sv
module xseg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/xseg_req_check.sv
module xseg_req_check #(
  parameter int LEN_W = 16
) (
  input  logic             addr_lsb,
  input  logic [LEN_W-1:0] len,
  input  logic             is_write,
  output logic             illegal,
  output logic             zero_len,
  output logic             pad_needed,
  output logic [LEN_W:0]   eff_len
);

  // Reads need both address and size even; writes only need the address even.
  always_comb begin
    illegal    = addr_lsb | (~is_write & len[0]);
    pad_needed = is_write & len[0];
    zero_len   = (len == '0);
    eff_len    = {1'b0, len} + {{LEN_W{1'b0}}, pad_needed};
  end

endmodule

// File: rtl/xseg_width_sel.sv
module xseg_width_sel
  import xseg_pkg::*;
#(
  parameter int REM_W     = 17,
  parameter int BURST_MAX = 240,
  parameter int SEG_LEN_W = 8
) (
  input  logic [2:0]           addr_lo,
  input  logic [REM_W-1:0]     remain,
  input  logic                 is_write,
  output logic [2:0]           opcode,
  output logic [SEG_LEN_W-1:0] seg_len
);

  localparam logic [REM_W-1:0] CAP      = REM_W'(BURST_MAX);
  localparam logic [REM_W-1:0] TWO      = REM_W'(2);
  localparam logic [REM_W-1:0] SIX      = REM_W'(6);

  seg_kind_e        kind;
  logic [REM_W-1:0] rem_rounded;
  logic [REM_W-1:0] burst_len;
  logic             half_pick;
  logic             word_pick;

  always_comb begin
    rem_rounded = {remain[REM_W-1:3], 3'b000};
    burst_len   = (rem_rounded > CAP) ? CAP : rem_rounded;
    // Fixed priority: half first, then word, then burst.
    half_pick   = (addr_lo == 3'd2) || (addr_lo == 3'd6) || (remain == TWO);
    word_pick   = (addr_lo == 3'd4) || (remain <= SIX);
    if (half_pick) begin
      kind    = SEG_HALF;
      seg_len = SEG_LEN_W'(2);
    end else if (word_pick) begin
      kind    = SEG_WORD;
      seg_len = SEG_LEN_W'(4);
    end else begin
      kind    = SEG_BURST;
      seg_len = SEG_LEN_W'(burst_len);
    end
    opcode = kind_opcode(kind, is_write);
  end

endmodule

// File: rtl/xseg_seq.sv
module xseg_seq
  import xseg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REM_W     = 17,
  parameter int SEG_LEN_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [REM_W-1:0]     req_eff_len,
  input  logic                 req_write,
  input  logic                 req_pad,
  input  logic                 req_illegal,
  input  logic                 req_zero,
  input  logic [SEG_LEN_W-1:0] seg_len,
  input  logic                 seg_ready,
  output logic                 seg_valid,
  output logic [ADDR_W-1:0]    cur_addr,
  output logic [REM_W-1:0]     cur_remain,
  output logic                 cur_write,
  output logic                 seg_pad,
  output logic                 done,
  output logic                 err
);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [REM_W-1:0]  remain_q, remain_d;
  logic              write_q, write_d;
  logic              pad_q, pad_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              ctx_en;
  logic              req_fire;
  logic              seg_fire;
  logic              seg_last;
  logic [REM_W-1:0]  seg_len_ext;

  always_comb begin
    req_ready   = (state_q == ST_IDLE);
    seg_valid   = (state_q == ST_RUN);
    req_fire    = req_valid & req_ready;
    seg_fire    = seg_valid & seg_ready;
    seg_len_ext = REM_W'(seg_len);
    seg_last    = (remain_q == seg_len_ext);
  end

  // Next-state process
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    write_d  = write_q;
    pad_d    = pad_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    ctx_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          if (req_illegal) begin
            err_d = 1'b1;
          end else if (req_zero) begin
            done_d = 1'b1;
          end else begin
            ctx_en   = 1'b1;
            state_d  = ST_RUN;
            addr_d   = req_addr;
            remain_d = req_eff_len;
            write_d  = req_write;
            pad_d    = req_pad;
          end
        end
      end
      default: begin
        if (seg_fire) begin
          ctx_en   = 1'b1;
          addr_d   = addr_q + ADDR_W'(seg_len);
          remain_d = remain_q - seg_len_ext;
          if (seg_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      remain_q <= '0;
      write_q  <= 1'b0;
      pad_q    <= 1'b0;
    end else if (ctx_en) begin
      addr_q   <= addr_d;
      remain_q <= remain_d;
      write_q  <= write_d;
      pad_q    <= pad_d;
    end
  end

  assign cur_addr   = addr_q;
  assign cur_remain = remain_q;
  assign cur_write  = write_q;
  assign seg_pad    = seg_valid & pad_q & seg_last;
  assign done       = done_q;
  assign err        = err_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(cur_addr) && $stable(cur_remain)); // R10

  AST_ERR_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_fire) && !seg_valid); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && !seg_valid); // R9

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R8

endmodule

// File: rtl/xfer_segmenter.sv
module xfer_segmenter
  import xseg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BURST_MAX = 240,
  parameter int SEG_LEN_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 req_write,
  output logic                 seg_valid,
  input  logic                 seg_ready,
  output logic [2:0]           seg_opcode,
  output logic [ADDR_W-1:0]    seg_addr,
  output logic [SEG_LEN_W-1:0] seg_len,
  output logic                 seg_pad,
  output logic                 done,
  output logic                 err
);

  localparam int REM_W = LEN_W + 1;

  logic             rst_sync_n;
  logic             chk_illegal;
  logic             chk_zero;
  logic             chk_pad;
  logic [REM_W-1:0] chk_eff_len;
  logic [REM_W-1:0] cur_remain;
  logic             cur_write;

  xseg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xseg_req_check #(.LEN_W(LEN_W)) u_req_check (
    .addr_lsb   (req_addr[0]),
    .len        (req_len),
    .is_write   (req_write),
    .illegal    (chk_illegal),
    .zero_len   (chk_zero),
    .pad_needed (chk_pad),
    .eff_len    (chk_eff_len)
  );

  xseg_width_sel #(
    .REM_W     (REM_W),
    .BURST_MAX (BURST_MAX),
    .SEG_LEN_W (SEG_LEN_W)
  ) u_width_sel (
    .addr_lo  (seg_addr[2:0]),
    .remain   (cur_remain),
    .is_write (cur_write),
    .opcode   (seg_opcode),
    .seg_len  (seg_len)
  );

  xseg_seq #(
    .ADDR_W    (ADDR_W),
    .REM_W     (REM_W),
    .SEG_LEN_W (SEG_LEN_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_eff_len (chk_eff_len),
    .req_write   (req_write),
    .req_pad     (chk_pad),
    .req_illegal (chk_illegal),
    .req_zero    (chk_zero),
    .seg_len     (seg_len),
    .seg_ready   (seg_ready),
    .seg_valid   (seg_valid),
    .cur_addr    (seg_addr),
    .cur_remain  (cur_remain),
    .cur_write   (cur_write),
    .seg_pad     (seg_pad),
    .done        (done),
    .err         (err)
  );

  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_valid && seg_len == SEG_LEN_W'(2) |-> seg_addr[0] == 1'b0 && seg_opcode[2:1] == 2'b00); // R1

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_valid && seg_len == SEG_LEN_W'(4) |-> seg_addr[1:0] == 2'b00 && seg_opcode[2:1] == 2'b01); // R2

  AST_BURST_SHAPE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_valid && seg_len > SEG_LEN_W'(4) |->
      seg_addr[2:0] == 3'b000 && seg_len[2:0] == 3'b000 &&
      seg_len <= SEG_LEN_W'(BURST_MAX) && seg_opcode[2:1] == 2'b10); // R3

  AST_OPCODE_DIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_valid |-> seg_opcode[0] == cur_write); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_valid && seg_ready && !done && cur_remain != REM_W'(seg_len) |=>
      seg_valid && seg_addr == $past(seg_addr) + ADDR_W'($past(seg_len))); // R5

  AST_PAD_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_pad |-> seg_opcode[0] && seg_valid); // R7

endmodule

// File: tb/xfer_segmenter_bench.sv
module xfer_segmenter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic        req_write;
  logic        seg_valid;
  logic        seg_ready;
  logic [2:0]  seg_opcode;
  logic [31:0] seg_addr;
  logic [7:0]  seg_len;
  logic        seg_pad;
  logic        done;
  logic        err;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [2:0]  exp_op   [64];
  logic [31:0] exp_addr [64];
  logic [7:0]  exp_len  [64];
  logic        exp_pad  [64];
  int          exp_n;
  logic [7:0]  obs_len  [64];

  always #4 clk = ~clk;

  xfer_segmenter u_xfer_segmenter (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_write  (req_write),
    .seg_valid  (seg_valid),
    .seg_ready  (seg_ready),
    .seg_opcode (seg_opcode),
    .seg_addr   (seg_addr),
    .seg_len    (seg_len),
    .seg_pad    (seg_pad),
    .done       (done),
    .err        (err)
  );

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference segmentation built from the requirement text.
  task automatic build_model(input logic [31:0] addr, input int len, input bit wr);
    int          rem;
    int          l;
    logic [2:0]  op;
    logic [31:0] a;
    rem   = (wr && (len % 2 == 1)) ? len + 1 : len;
    a     = addr;
    exp_n = 0;
    while (rem > 0 && exp_n < 64) begin
      if (a[2:0] == 3'd2 || a[2:0] == 3'd6 || rem == 2) begin
        l = 2; op = 3'd0;
      end else if (a[2:0] == 3'd4 || rem <= 6) begin
        l = 4; op = 3'd2;
      end else begin
        l = (rem / 8) * 8;
        if (l > 240) l = 240;
        op = 3'd4;
      end
      exp_op[exp_n]   = op | {2'b00, wr};
      exp_addr[exp_n] = a;
      exp_len[exp_n]  = 8'(l);
      exp_pad[exp_n]  = wr && (len % 2 == 1) && (rem == l);
      exp_n++;
      a   = a + 32'(l);
      rem = rem - l;
    end
  endtask

  task automatic offer_req(input logic [31:0] addr, input int len, input bit wr);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "req_ready while idle", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = addr;
    req_len   = 16'(len);
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_segments(input string tag, input logic [31:0] addr, input int len,
                              input bit wr, input int stall_mod);
    int          idx;
    int          cyc;
    bit          held;
    logic [31:0] p_addr;
    logic [7:0]  p_len;
    logic [2:0]  p_op;
    bit          rdy;
    build_model(addr, len, wr);
    offer_req(addr, len, wr);
    chk(req_ready == 1'b0, "R9", {tag, " req_ready busy"}, req_ready, 0);
    idx  = 0;
    cyc  = 0;
    held = 1'b0;
    p_addr = '0; p_len = '0; p_op = '0;
    while (idx < exp_n && cyc < 4000) begin
      chk(seg_valid == 1'b1, "R9", {tag, " seg_valid pending"}, seg_valid, 1);
      if (held) begin
        chk(seg_addr == p_addr && seg_len == p_len && seg_opcode == p_op, "R10",
            {tag, " held segment"}, seg_addr, p_addr);
      end
      rdy = (stall_mod == 0) || (cyc % stall_mod != 0);
      seg_ready = rdy;
      if (rdy) begin
        chk(seg_opcode == exp_op[idx], "R4", {tag, " opcode"}, seg_opcode, exp_op[idx]);
        chk(seg_addr == exp_addr[idx], "R5", {tag, " address"}, seg_addr, exp_addr[idx]);
        chk(seg_len == exp_len[idx], "R3", {tag, " length"}, seg_len, exp_len[idx]);
        chk(seg_pad == exp_pad[idx], "R7", {tag, " pad flag"}, seg_pad, exp_pad[idx]);
        obs_len[idx] = seg_len;
        idx++;
      end
      held   = !rdy;
      p_addr = seg_addr; p_len = seg_len; p_op = seg_opcode;
      cyc++;
      @(negedge clk);
    end
    seg_ready = 1'b0;
    chk(done == 1'b1, "R9", {tag, " done after last"}, done, 1);
    chk(seg_valid == 1'b0, "R9", {tag, " no extra segment"}, seg_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", {tag, " done one cycle"}, done, 0);
  endtask

  task automatic test_reset();
    chk(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);
    chk(seg_valid == 1'b0, "R11", "reset seg_valid", seg_valid, 0);
    chk(done == 1'b0, "R11", "reset done", done, 0);
    chk(err == 1'b0, "R11", "reset err", err, 0);
  endtask

  task automatic test_long_read();
    int golden [6] = '{2, 4, 240, 8, 4, 2};
    run_segments("read260", 32'h6003_0002, 260, 1'b0, 0);
    chk(exp_n == 6, "R3", "read260 segment count", exp_n, 6);
    foreach (golden[i]) begin
      chk(obs_len[i] == 8'(golden[i]), "R1", "read260 listed length", obs_len[i], golden[i]);
    end
  endtask

  task automatic test_small_reads();
    run_segments("read6", 32'h0000_0010, 6, 1'b0, 0);   // R2 then R1: 4 then 2
    run_segments("read2", 32'h0000_0020, 2, 1'b0, 0);   // R1 exact two
    run_segments("read8at4", 32'h0000_0034, 8, 1'b0, 0); // R2 align four
  endtask

  task automatic test_write_stalled();
    run_segments("write260", 32'h6003_0002, 260, 1'b1, 3); // R4 R10
  endtask

  task automatic test_pad();
    run_segments("write13", 32'h0000_0100, 13, 1'b1, 0); // R7
    run_segments("write1", 32'h0000_0206, 1, 1'b1, 2);   // R7 single pad
  endtask

  task automatic test_wrap();
    run_segments("wrap", 32'hFFFF_FFFA, 16, 1'b1, 0); // R5
  endtask

  task automatic test_cap();
    run_segments("read1000", 32'h0000_0000, 1000, 1'b0, 2); // R3
  endtask

  task automatic expect_err(input string tag, input logic [31:0] addr, input int len, input bit wr);
    offer_req(addr, len, wr);
    chk(err == 1'b1, "R6", {tag, " err pulse"}, err, 1);
    chk(seg_valid == 1'b0, "R6", {tag, " no segment"}, seg_valid, 0);
    chk(done == 1'b0, "R6", {tag, " no done"}, done, 0);
    @(negedge clk);
    chk(err == 1'b0, "R6", {tag, " err one cycle"}, err, 0);
    chk(seg_valid == 1'b0, "R6", {tag, " still no segment"}, seg_valid, 0);
  endtask

  task automatic test_errors();
    expect_err("rd odd addr", 32'h0000_0101, 4, 1'b0);
    expect_err("rd odd len", 32'h0000_0100, 5, 1'b0);
    expect_err("wr odd addr", 32'h0000_0103, 8, 1'b1);
  endtask

  task automatic expect_zero(input bit wr);
    offer_req(32'h0000_0040, 0, wr);
    chk(done == 1'b1, "R8", "zero length done", done, 1);
    chk(seg_valid == 1'b0, "R8", "zero length no segment", seg_valid, 0);
    chk(err == 1'b0, "R8", "zero length no err", err, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "zero length done one cycle", done, 0);
    chk(seg_valid == 1'b0, "R8", "zero length stays idle", seg_valid, 0);
  endtask

  task automatic test_zero();
    expect_zero(1'b0);
    expect_zero(1'b1);
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_len   = '0;
    req_write = 1'b0;
    seg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_long_read();
    test_small_reads();
    test_write_stalled();
    test_pad();
    test_wrap();
    test_cap();
    test_errors();
    test_zero();
    finish_run();
  end

endmodule